// File: doc/BRIEF.md
# Boot Table Loader for a Secondary Serial Bus

After reset, this sequencer copies a configuration table from a serial EPROM into the chip's own register file and into other devices on a secondary two-wire bus. It drives the bus through a byte-level master engine. The engine takes one command per transfer, either START, STOP, WRITE a byte or READ a byte with ACK or NACK, and returns exactly one response per command. Bit timing belongs to the engine and is not part of this block. The table is a list of three-byte entries: destination station, register address and data byte. Each entry is fetched with a random read. The read first sets the EPROM pointer, then reads the three bytes in sequence and answers the last byte with NACK.

The first two entries of the table are ordinary entries. They normally write the chip's own count registers, low byte at 1Ah and high byte at 1Bh. Once both are applied, the sequencer takes the 16-bit count from those registers and processes that many further entries. The count is limited so that the whole table fits in the EPROM. An entry addressed to the chip's own station is applied locally and causes no bus traffic. Any other entry becomes a three-byte write on the bus.

While a load is running, `init_active` is high and host writes are dropped, but host reads still work. A load starts on external reset. It also starts when the host writes a one to bit 0 of register 00h; that bit always reads back as zero. If the EPROM fails to acknowledge, the load stops and `no_dev` is set. If a remote device fails to acknowledge, `no_dev` is also set, but the load goes on with the next entry.

Top module: `boot_loader`

## Requirements
- R1: While reset is asserted and right after it is released, `init_active` is 1, and the first bus command of the load is START.
- R2: For an entry at table offset `o`, the commands are issued in this order:
  - START
  - WRITE `A0h | (o[10:8] << 1)`
  - WRITE `o[7:0]`
  - START
  - WRITE `A1h | (o[10:8] << 1)`
  - READ with ACK
  - READ with ACK
  - READ with NACK
  - STOP

  Command op codes are START=0, STOP=1, WRITE=2 and READ=3.
- R3: The header entries are read from offsets 0 and 3. The entries that follow are read from offsets 6, 9, 12 and so on. The number of following entries is `{reg 1Bh, reg 1Ah}`, sampled after the second header entry has been applied.
- R4: An entry is applied to the local register file, with no bus transaction, when bits [7:1] of its destination equal bits [7:1] of register FFh. Register FFh resets to 34h and can be written by the host.
- R5: Any other entry is written on the bus as: START, WRITE `{dest[7:1],0}`, WRITE register, WRITE data, STOP.
- R6: A count of zero ends the load right after the second header entry. `init_active` then drops and no further command is issued.
- R7: The number of entries after the header is clamped to `EPROM_BYTES/3 - 2` (680 by default).
- R8: If any address or offset WRITE to the EPROM is not acknowledged, the sequencer issues STOP, sets `no_dev`, ends the load and issues no further commands.
- R9: While `init_active` is 1, host writes have no effect and host reads return the register contents. When idle, host writes take effect.
- R10: A host write to register 00h with bit 0 set raises `init_active` at the accepting edge. It clears `no_dev` one edge later. Register 00h bit 0 always reads 0.
- R11: A NACK during a remote entry sets `no_dev` and issues STOP, and the load continues with the next entry.
- R12: A command stays valid with op, byte and NACK flag stable until it is accepted. Exactly one response is taken per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a load |
| host_wr_valid | input | 1 | Host register write request |
| host_wr_ready | output | 1 | Always 1; writes made during a load are accepted and dropped |
| host_wr_addr | input | 8 | Host write register address |
| host_wr_data | input | 8 | Host write data |
| host_rd_addr | input | 8 | Host read register address |
| host_rd_data | output | 8 | Combinational read data |
| init_active | output | 1 | High while a load runs |
| no_dev | output | 1 | A device failed to acknowledge during the last load |
| m_cmd_valid | output | 1 | Bus command valid |
| m_cmd_ready | input | 1 | Bus engine accepts the command |
| m_cmd_op | output | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| m_cmd_byte | output | 8 | Byte for WRITE |
| m_cmd_nack | output | 1 | For READ: answer the byte with NACK |
| m_rsp_valid | input | 1 | Response valid |
| m_rsp_ready | output | 1 | Sequencer is waiting for a response |
| m_rsp_byte | input | 8 | Byte returned by READ |
| m_rsp_ack | input | 1 | For WRITE: the slave acknowledged |

## Verification
Each command is answered by the bench's bus model one cycle after acceptance. The sequencer takes the answer on the next edge, so a command costs two cycles when there is no back-pressure. Results of a load are checked at the first falling edge on which `init_active` reads low. By then every local write has landed, so host reads there are final. The effects of a master-reset write are sampled at exact edges: `init_active` at the falling edge right after the accepting edge, and `no_dev` one cycle later. The bus model logs every accepted command and checks the EPROM offset against the expected `3*n` sequence, so both ordering and block bits are compared.

// File: rtl/boot_loader_pkg.sv
package boot_loader_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    ST_EP_START,
    ST_EP_DEVW,
    ST_EP_OFS,
    ST_EP_RSTART,
    ST_EP_DEVR,
    ST_EP_RD0,
    ST_EP_RD1,
    ST_EP_RD2,
    ST_EP_STOP,
    ST_RM_START,
    ST_RM_DEV,
    ST_RM_REG,
    ST_RM_DATA,
    ST_RM_STOP
  } step_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_CMD,
    PH_RSP,
    PH_LOCAL,
    PH_NEXT,
    PH_CHK
  } phase_e;

  typedef enum logic [1:0] {
    TR_HDR0,
    TR_HDR1,
    TR_BODY
  } tbl_part_e;

endpackage

// File: rtl/bl_regfile.sv
module bl_regfile #(
  parameter int          AW          = 8,
  parameter logic [7:0]  OWN_RESET   = 8'h34,
  parameter logic [7:0]  CTRL_ADDR   = 8'h00,
  parameter logic [7:0]  CNT_LO_ADDR = 8'h1A,
  parameter logic [7:0]  CNT_HI_ADDR = 8'h1B,
  parameter logic [7:0]  STN_ADDR    = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          host_wr_valid,
  output logic          host_wr_ready,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [7:0]    host_wr_data,
  input  logic [AW-1:0] host_rd_addr,
  output logic [7:0]    host_rd_data,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  output logic [15:0]   count_o,
  output logic [6:0]    own_stn_o,
  output logic          mreset_o
);
  localparam int NREG = 2 ** AW;

  logic [7:0] regs [NREG];
  logic       host_we;

  function automatic logic [7:0] scrub(input logic [AW-1:0] a, input logic [7:0] d);
    return (a == AW'(CTRL_ADDR)) ? {d[7:1], 1'b0} : d;
  endfunction

  assign host_wr_ready = 1'b1;
  assign host_we       = host_wr_valid && !busy;
  assign mreset_o      = host_we && (host_wr_addr == AW'(CTRL_ADDR)) && host_wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == int'(STN_ADDR)) ? OWN_RESET : 8'h00;
    end else if (ld_we) begin
      regs[ld_addr] <= scrub(ld_addr, ld_data);
    end else if (host_we) begin
      regs[host_wr_addr] <= scrub(host_wr_addr, host_wr_data);
    end
  end

  assign host_rd_data = regs[host_rd_addr];
  assign count_o      = {regs[AW'(CNT_HI_ADDR)], regs[AW'(CNT_LO_ADDR)]};
  assign own_stn_o    = regs[AW'(STN_ADDR)][7:1];

endmodule

// File: rtl/bl_tracker.sv
module bl_tracker
  import boot_loader_pkg::*;
#(
  parameter int OFS_W    = 11,
  parameter int MAX_BODY = 680,
  parameter int TRI_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  input  logic [15:0]      count,
  output logic [OFS_W-1:0] offset,
  output logic             more
);
  tbl_part_e          part;
  logic [TRI_W-1:0]   remain;
  logic [TRI_W-1:0]   clamped;

  assign clamped = (count > 16'(MAX_BODY)) ? TRI_W'(MAX_BODY) : TRI_W'(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
      part   <= TR_HDR0;
      remain <= '0;
    end else if (start) begin
      offset <= '0;
      part   <= TR_HDR0;
      remain <= '0;
    end else if (advance) begin
      offset <= offset + OFS_W'(3);
      case (part)
        TR_HDR0: part <= TR_HDR1;
        TR_HDR1: begin
          part   <= TR_BODY;
          remain <= clamped;
        end
        default: remain <= remain - TRI_W'(1);
      endcase
    end
  end

  assign more = (part != TR_BODY) || (remain != '0);

endmodule

// File: rtl/bl_seq.sv
module bl_seq
  import boot_loader_pkg::*;
#(
  parameter int         OFS_W      = 11,
  parameter logic [7:0] EPROM_STN  = 8'hA0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset,
  input  logic [6:0]       own_stn,
  input  logic [OFS_W-1:0] offset,
  input  logic             more,
  output logic             trk_start,
  output logic             trk_advance,
  output logic             ld_we,
  output logic [7:0]       ld_addr,
  output logic [7:0]       ld_data,
  output logic             init_active,
  output logic             no_dev,
  output logic             m_cmd_valid,
  input  logic             m_cmd_ready,
  output logic [1:0]       m_cmd_op,
  output logic [7:0]       m_cmd_byte,
  output logic             m_cmd_nack,
  input  logic             m_rsp_valid,
  output logic             m_rsp_ready,
  input  logic [7:0]       m_rsp_byte,
  input  logic             m_rsp_ack
);
  phase_e     phase;
  step_e      step;
  logic       abort;
  logic [6:0] dest;
  logic [7:0] rega;
  logic [7:0] datb;
  logic [2:0] blk;
  logic [7:0] dev_w;
  bus_op_e    op;

  function automatic step_e step_after(input step_e s);
    case (s)
      ST_EP_START:  return ST_EP_DEVW;
      ST_EP_DEVW:   return ST_EP_OFS;
      ST_EP_OFS:    return ST_EP_RSTART;
      ST_EP_RSTART: return ST_EP_DEVR;
      ST_EP_DEVR:   return ST_EP_RD0;
      ST_EP_RD0:    return ST_EP_RD1;
      ST_EP_RD1:    return ST_EP_RD2;
      ST_EP_RD2:    return ST_EP_STOP;
      ST_RM_START:  return ST_RM_DEV;
      ST_RM_DEV:    return ST_RM_REG;
      ST_RM_REG:    return ST_RM_DATA;
      ST_RM_DATA:   return ST_RM_STOP;
      default:      return ST_EP_START;
    endcase
  endfunction

  assign blk   = 3'(offset >> 8);
  assign dev_w = EPROM_STN | {4'd0, blk, 1'b0};

  always_comb begin
    op         = OP_START;
    m_cmd_byte = 8'h00;
    m_cmd_nack = 1'b0;
    case (step)
      ST_EP_START, ST_EP_RSTART, ST_RM_START: op = OP_START;
      ST_EP_STOP, ST_RM_STOP:                 op = OP_STOP;
      ST_EP_DEVW: begin op = OP_WRITE; m_cmd_byte = dev_w; end
      ST_EP_OFS:  begin op = OP_WRITE; m_cmd_byte = 8'(offset); end
      ST_EP_DEVR: begin op = OP_WRITE; m_cmd_byte = dev_w | 8'h01; end
      ST_EP_RD0, ST_EP_RD1: op = OP_READ;
      ST_EP_RD2:  begin op = OP_READ; m_cmd_nack = 1'b1; end
      ST_RM_DEV:  begin op = OP_WRITE; m_cmd_byte = {dest, 1'b0}; end
      ST_RM_REG:  begin op = OP_WRITE; m_cmd_byte = rega; end
      ST_RM_DATA: begin op = OP_WRITE; m_cmd_byte = datb; end
      default:    op = OP_START;
    endcase
  end

  assign m_cmd_op    = op;
  assign m_cmd_valid = (phase == PH_CMD);
  assign m_rsp_ready = (phase == PH_RSP);
  assign trk_start   = (phase == PH_START);
  assign trk_advance = (phase == PH_NEXT);
  assign ld_we       = (phase == PH_LOCAL);
  assign ld_addr     = rega;
  assign ld_data     = datb;
  assign init_active = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_START;
      step   <= ST_EP_START;
      abort  <= 1'b0;
      no_dev <= 1'b0;
      dest   <= '0;
      rega   <= '0;
      datb   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (mreset) phase <= PH_START;
        PH_START: begin
          no_dev <= 1'b0;
          abort  <= 1'b0;
          step   <= ST_EP_START;
          phase  <= PH_CMD;
        end
        PH_CMD: if (m_cmd_ready) phase <= PH_RSP;
        PH_RSP: if (m_rsp_valid) begin
          phase <= PH_CMD;
          case (step)
            ST_EP_DEVW, ST_EP_OFS, ST_EP_DEVR: begin
              if (!m_rsp_ack) begin
                abort <= 1'b1;
                step  <= ST_EP_STOP;
              end else begin
                step  <= step_after(step);
              end
            end
            ST_EP_RD0: begin dest <= m_rsp_byte[7:1]; step <= ST_EP_RD1; end
            ST_EP_RD1: begin rega <= m_rsp_byte;      step <= ST_EP_RD2; end
            ST_EP_RD2: begin datb <= m_rsp_byte;      step <= ST_EP_STOP; end
            ST_EP_STOP: begin
              if (abort) begin
                no_dev <= 1'b1;
                phase  <= PH_IDLE;
              end else if (dest == own_stn) begin
                phase  <= PH_LOCAL;
              end else begin
                step   <= ST_RM_START;
              end
            end
            ST_RM_DEV, ST_RM_REG, ST_RM_DATA: begin
              if (!m_rsp_ack) begin
                no_dev <= 1'b1;
                step   <= ST_RM_STOP;
              end else begin
                step   <= step_after(step);
              end
            end
            ST_RM_STOP: phase <= PH_NEXT;
            default:    step  <= step_after(step);
          endcase
        end
        PH_LOCAL: phase <= PH_NEXT;
        PH_NEXT:  phase <= PH_CHK;
        PH_CHK: begin
          if (more) begin
            step  <= ST_EP_START;
            phase <= PH_CMD;
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int         EPROM_BYTES = 2048,
  parameter logic [7:0] EPROM_STN   = 8'hA0,
  parameter logic [7:0] OWN_RESET   = 8'h34,
  parameter logic [7:0] CTRL_ADDR   = 8'h00,
  parameter logic [7:0] CNT_LO_ADDR = 8'h1A,
  parameter logic [7:0] CNT_HI_ADDR = 8'h1B,
  parameter logic [7:0] STN_ADDR    = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr_valid,
  output logic       host_wr_ready,
  input  logic [7:0] host_wr_addr,
  input  logic [7:0] host_wr_data,
  input  logic [7:0] host_rd_addr,
  output logic [7:0] host_rd_data,
  output logic       init_active,
  output logic       no_dev,
  output logic       m_cmd_valid,
  input  logic       m_cmd_ready,
  output logic [1:0] m_cmd_op,
  output logic [7:0] m_cmd_byte,
  output logic       m_cmd_nack,
  input  logic       m_rsp_valid,
  output logic       m_rsp_ready,
  input  logic [7:0] m_rsp_byte,
  input  logic       m_rsp_ack
);
  localparam int OFS_W    = $clog2(EPROM_BYTES);
  localparam int MAX_BODY = EPROM_BYTES / 3 - 2;
  localparam int TRI_W    = $clog2(MAX_BODY + 1);

  logic             mreset;
  logic [6:0]       own_stn;
  logic [15:0]      count;
  logic [OFS_W-1:0] offset;
  logic             more;
  logic             trk_start;
  logic             trk_advance;
  logic             ld_we;
  logic [7:0]       ld_addr;
  logic [7:0]       ld_data;

  bl_regfile #(
    .AW(8), .OWN_RESET(OWN_RESET), .CTRL_ADDR(CTRL_ADDR),
    .CNT_LO_ADDR(CNT_LO_ADDR), .CNT_HI_ADDR(CNT_HI_ADDR), .STN_ADDR(STN_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(init_active),
    .host_wr_valid(host_wr_valid), .host_wr_ready(host_wr_ready),
    .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .count_o(count), .own_stn_o(own_stn), .mreset_o(mreset)
  );

  bl_tracker #(
    .OFS_W(OFS_W), .MAX_BODY(MAX_BODY), .TRI_W(TRI_W)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .start(trk_start), .advance(trk_advance),
    .count(count), .offset(offset), .more(more)
  );

  bl_seq #(
    .OFS_W(OFS_W), .EPROM_STN(EPROM_STN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .own_stn(own_stn),
    .offset(offset), .more(more), .trk_start(trk_start), .trk_advance(trk_advance),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .init_active(init_active), .no_dev(no_dev),
    .m_cmd_valid(m_cmd_valid), .m_cmd_ready(m_cmd_ready), .m_cmd_op(m_cmd_op),
    .m_cmd_byte(m_cmd_byte), .m_cmd_nack(m_cmd_nack),
    .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready),
    .m_rsp_byte(m_rsp_byte), .m_rsp_ack(m_rsp_ack)
  );

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_active,
  input logic       no_dev,
  input logic       m_cmd_valid,
  input logic       m_cmd_ready,
  input logic [1:0] m_cmd_op,
  input logic [7:0] m_cmd_byte,
  input logic       m_cmd_nack,
  input logic       m_rsp_ready
);

  // R12
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cmd_valid && !m_cmd_ready) |=> (m_cmd_valid && $stable(m_cmd_op) &&
                                       $stable(m_cmd_byte) && $stable(m_cmd_nack)));

  // R12
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_ready |-> !m_cmd_valid);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_active |-> !m_cmd_valid);

  // R10
  nodev_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(no_dev) |-> init_active);

  // R8
  nodev_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(no_dev) && !init_active) |-> $past(m_rsp_ready));

endmodule

bind boot_loader boot_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_active(init_active), .no_dev(no_dev),
  .m_cmd_valid(m_cmd_valid), .m_cmd_ready(m_cmd_ready), .m_cmd_op(m_cmd_op),
  .m_cmd_byte(m_cmd_byte), .m_cmd_nack(m_cmd_nack), .m_rsp_ready(m_rsp_ready)
);

// File: tb/sim_boot_loader.sv
`timescale 1ns/1ps
module sim_boot_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr_valid = 1'b0;
  logic       host_wr_ready;
  logic [7:0] host_wr_addr = 8'h00;
  logic [7:0] host_wr_data = 8'h00;
  logic [7:0] host_rd_addr = 8'h00;
  logic [7:0] host_rd_data;
  logic       init_active, no_dev;
  logic       m_cmd_valid, m_cmd_nack, m_rsp_ready;
  logic [1:0] m_cmd_op;
  logic [7:0] m_cmd_byte;
  logic       m_cmd_ready = 1'b1;
  logic       m_rsp_valid = 1'b0;
  logic [7:0] m_rsp_byte = 8'h00;
  logic       m_rsp_ack = 1'b0;

  always #2.5 clk = ~clk;

  boot_loader u0 (.*);

  int checks = 0;
  int errors = 0;

  // bus model state
  logic [7:0] rom [0:2047];
  bit   eprom_present = 1;
  bit   remote_present = 1;
  bit   bp_on = 0;
  int   ncmd, nrsp, ntrip, nrem, mism, bp_err;
  int   exp_ofs;
  logic [1:0] log_op [0:63];
  logic [7:0] log_b  [0:63];
  logic       log_n  [0:63];
  logic [7:0] rem_dev, rem_reg, rem_dat;

  task automatic clear_log();
    ncmd = 0; nrsp = 0; ntrip = 0; nrem = 0; mism = 0; bp_err = 0; exp_ofs = 0;
    rem_dev = 0; rem_reg = 0; rem_dat = 0;
  endtask

  initial begin
    int   sel = 0;
    bit   want_addr = 0;
    int   wb = 0;
    int   ptr = 0;
    int   cyc = 0;
    bit   pv = 0, pr = 0;
    logic [1:0] pop = 0;
    logic [7:0] pb = 0;
    logic       pn = 0;
    logic [7:0] rb;
    logic       ra;
    clear_log();
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        m_rsp_valid <= 1'b0;
        sel = 0; pv = 0;
      end else begin
        if (m_rsp_valid && m_rsp_ready) begin
          m_rsp_valid <= 1'b0;
          nrsp++;
        end
        if (pv && !pr && (!m_cmd_valid || m_cmd_op != pop || m_cmd_byte != pb || m_cmd_nack != pn))
          bp_err++;
        if (m_cmd_valid && m_cmd_ready) begin
          rb = 8'h00; ra = 1'b1;
          if (ncmd < 64) begin
            log_op[ncmd] = m_cmd_op; log_b[ncmd] = m_cmd_byte; log_n[ncmd] = m_cmd_nack;
          end
          ncmd++;
          case (m_cmd_op)
            2'd0: want_addr = 1;
            2'd1: sel = 0;
            2'd2: begin
              if (want_addr) begin
                want_addr = 0;
                if (m_cmd_byte[7:4] == 4'hA) begin
                  sel = 1; ra = eprom_present;
                  if (!m_cmd_byte[0] && eprom_present) begin
                    ptr = {m_cmd_byte[3:1], 8'h00};
                    if (m_cmd_byte[3:1] != 3'((exp_ofs >> 8) & 7)) mism++;
                  end
                end else begin
                  sel = 2; wb = 0; ra = remote_present;
                  if (remote_present) rem_dev = m_cmd_byte;
                end
              end else if (sel == 1) begin
                ptr = (ptr & 32'h700) | m_cmd_byte;
                if (ptr != (exp_ofs & 2047)) mism++;
              end else if (sel == 2) begin
                if (wb == 0) rem_reg = m_cmd_byte;
                else begin rem_dat = m_cmd_byte; nrem++; end
                wb++;
              end
            end
            default: begin
              rb = rom[ptr];
              ptr = (ptr + 1) % 2048;
              if (m_cmd_nack) begin ntrip++; exp_ofs += 3; end
            end
          endcase
          m_rsp_valid <= 1'b1;
          m_rsp_byte  <= rb;
          m_rsp_ack   <= ra;
        end
        pv = m_cmd_valid; pr = m_cmd_ready; pop = m_cmd_op; pb = m_cmd_byte; pn = m_cmd_nack;
        m_cmd_ready <= bp_on ? ((cyc % 3) != 0) : 1'b1;
        cyc++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rom_clear();
    for (int i = 0; i < 2048; i++) rom[i] = 8'h00;
  endtask

  task automatic put(input int idx, input logic [7:0] d, input logic [7:0] r, input logic [7:0] v);
    rom[3*idx] = d; rom[3*idx+1] = r; rom[3*idx+2] = v;
  endtask

  task automatic header(input logic [7:0] d, input int cnt);
    put(0, d, 8'h1A, 8'(cnt));
    put(1, d, 8'h1B, 8'(cnt >> 8));
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clear_log();
    repeat (3) @(negedge clk);
    chk(init_active == 1'b1, "R1 init_active in reset", init_active, 1);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (init_active && n < 60000) begin @(negedge clk); n++; end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr_valid = 1'b1; host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    host_rd_addr = a;
    #1;
    d = host_rd_data;
  endtask

  task automatic t_count_zero();
    logic [7:0] v;
    int bad = 0;
    logic [1:0] eo [0:8];
    logic [7:0] eb [0:8];
    rom_clear(); header(8'h34, 0);
    eprom_present = 1; remote_present = 1; bp_on = 0;
    hard_reset();
    wait_idle();
    eo = '{2'd0, 2'd2, 2'd2, 2'd0, 2'd2, 2'd3, 2'd3, 2'd3, 2'd1};
    eb = '{8'h00, 8'hA0, 8'h00, 8'h00, 8'hA1, 8'h00, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < 9; i++) begin
      if (log_op[i] != eo[i]) bad++;
      if (log_op[i] == 2'd2 && log_b[i] != eb[i]) bad++;
      if (log_op[i] == 2'd3 && log_n[i] != (i == 7)) bad++;
    end
    chk(log_op[0] == 2'd0, "R1 first command START", log_op[0], 0);
    chk(bad == 0, "R2 entry read sequence", bad, 0);
    chk(ntrip == 2 && ncmd == 18, "R6 zero count stops after header", ncmd, 18);
    chk(init_active == 1'b0 && no_dev == 1'b0, "R6 idle after header", {init_active, no_dev}, 0);
    host_read(8'h1A, v);
    chk(v == 8'h00 && nrem == 0, "R4 header applied locally", v, 0);
  endtask

  task automatic t_mixed_bp();
    logic [7:0] v;
    int bad = 0;
    rom_clear(); header(8'h34, 3);
    put(2, 8'h43, 8'h10, 8'h5C);
    put(3, 8'h34, 8'h50, 8'hAB);
    put(4, 8'h35, 8'h51, 8'hCD);
    eprom_present = 1; remote_present = 1; bp_on = 1;
    hard_reset();
    wait_idle();
    bp_on = 0;
    chk(ntrip == 5 && mism == 0, "R3 body entries at 6,9,12", ntrip, 5);
    if (log_op[27] != 2'd0) bad++;
    if (log_op[28] != 2'd2 || log_b[28] != 8'h42) bad++;
    if (log_op[29] != 2'd2 || log_b[29] != 8'h10) bad++;
    if (log_op[30] != 2'd2 || log_b[30] != 8'h5C) bad++;
    if (log_op[31] != 2'd1) bad++;
    chk(bad == 0 && nrem == 1, "R5 remote write sequence", bad, 0);
    host_read(8'h50, v);
    chk(v == 8'hAB, "R4 local entry reg50", v, 8'hAB);
    host_read(8'h51, v);
    chk(v == 8'hCD, "R4 lsb of destination ignored", v, 8'hCD);
    chk(bp_err == 0, "R12 command stable under back-pressure", bp_err, 0);
    chk(ncmd == nrsp, "R12 one response per command", nrsp, ncmd);
  endtask

  task automatic t_clamp();
    logic [7:0] v;
    rom_clear(); header(8'h34, 16'h7FFF);
    for (int i = 0; i < 680; i++) put(2 + i, 8'h34, 8'h60, 8'(i));
    eprom_present = 1; remote_present = 1; bp_on = 0;
    hard_reset();
    wait_idle();
    chk(ntrip == 682, "R7 body clamped to 680", ntrip, 682);
    chk(mism == 0, "R2 block bits and offsets", mism, 0);
    host_read(8'h60, v);
    chk(v == 8'hA7, "R7 last entry applied", v, 8'hA7);
  endtask

  task automatic t_no_eprom();
    eprom_present = 0; remote_present = 1; bp_on = 0;
    hard_reset();
    wait_idle();
    repeat (5) @(negedge clk);
    chk(no_dev == 1'b1 && init_active == 1'b0, "R8 abort flags", {no_dev, init_active}, 2);
    chk(ncmd == 3 && log_op[2] == 2'd1, "R8 STOP then silence", ncmd, 3);
  endtask

  task automatic t_remote_nack();
    logic [7:0] v;
    rom_clear(); header(8'h34, 2);
    put(2, 8'h43, 8'h01, 8'h02);
    put(3, 8'h34, 8'h52, 8'h77);
    eprom_present = 1; remote_present = 0; bp_on = 0;
    hard_reset();
    wait_idle();
    host_read(8'h52, v);
    chk(no_dev == 1'b1 && ntrip == 4, "R11 nack sets flag and continues", ntrip, 4);
    chk(v == 8'h77, "R11 next entry applied", v, 8'h77);
    remote_present = 1;
  endtask

  task automatic t_host_during_load();
    logic [7:0] v;
    rom_clear(); header(8'h34, 20);
    for (int i = 0; i < 20; i++) put(2 + i, 8'h34, 8'h61, 8'(i));
    eprom_present = 1; remote_present = 1; bp_on = 0;
    hard_reset();
    repeat (20) @(negedge clk);
    host_write(8'h70, 8'h99);
    host_read(8'hFF, v);
    chk(init_active == 1'b1 && v == 8'h34, "R9 read during load", v, 8'h34);
    wait_idle();
    host_read(8'h70, v);
    chk(v == 8'h00, "R9 write during load dropped", v, 0);
    host_write(8'h70, 8'h99);
    host_read(8'h70, v);
    chk(v == 8'h99, "R9 write when idle", v, 8'h99);
  endtask

  task automatic t_master_reset();
    logic [7:0] v;
    rom_clear(); header(8'h34, 1);
    put(2, 8'h43, 8'h05, 8'h06);
    remote_present = 0;
    clear_log();
    host_write(8'h00, 8'h03);
    chk(init_active == 1'b1, "R10 load starts on master reset", init_active, 1);
    host_read(8'h00, v);
    chk(v == 8'h02, "R10 bit0 reads zero", v, 8'h02);
    wait_idle();
    chk(no_dev == 1'b1, "R10 setup nack", no_dev, 1);
    remote_present = 1;
    clear_log();
    host_write(8'h00, 8'h01);
    @(negedge clk);
    chk(no_dev == 1'b0, "R10 no_dev cleared", no_dev, 0);
    wait_idle();
    chk(nrem == 1 && rem_dev == 8'h42, "R10 reload done", nrem, 1);
  endtask

  task automatic t_station_change();
    logic [7:0] v;
    host_write(8'hFF, 8'h20);
    rom_clear(); header(8'h21, 2);
    put(2, 8'h20, 8'h62, 8'h55);
    put(3, 8'h35, 8'h63, 8'h66);
    clear_log();
    host_write(8'h00, 8'h01);
    wait_idle();
    host_read(8'h62, v);
    chk(v == 8'h55, "R4 new station local", v, 8'h55);
    host_read(8'h63, v);
    chk(v == 8'h00 && nrem == 1 && rem_dev == 8'h34, "R4 old station remote", rem_dev, 8'h34);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rom_clear();
    t_count_zero();
    t_mixed_bp();
    t_clamp();
    t_no_eprom();
    t_remote_nack();
    t_host_during_load();
    t_master_reset();
    t_station_change();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule